// File: doc/BRIEF.md
# LIN Slave Frame Responder

This block is the frame-level front end of a LIN slave node. It sits on a single receive line and a single transmit line and takes an oversampling strobe running at a fixed multiple of the bit rate. It watches the bus for a long dominant break, checks the synchronisation byte that follows, and then reads and parity-checks the protected identifier that selects the frame.

A configuration vector holds one entry per 6-bit frame identifier. Each entry says whether the node ignores, consumes or answers that frame, how many data bytes it carries, and which checksum model applies. For a consumed frame the block collects the data bytes and the trailing checksum and reports the result with a single-cycle strobe. For an answered frame it turns the line around and sends bytes from a local buffer followed by the checksum it computes. Errors in parity, checksum and byte framing are each reported on their own single-cycle flag.

The transmit output is meant to drive the bus through a wired-AND transceiver, so the receiver also sees the node's own bytes. The block ignores that echo.

Top module: `lin_slave_responder`

## Requirements
- R1: A header starts only after the synchronised line has been low for at least 13 bit times (13·OVS ticks) and then high for at least one bit time. A low period of 10 bit times followed by a full header and response produces no strobe and no flag.
- R2: The first byte after the break must be 0x55. Any other value ends the frame silently, with no flag, and the block ignores every byte until the next break.
- R3: The identifier byte holds the frame ID in bits 5:0, P0 in bit 6 and P1 in bit 7. P0 = ID0^ID1^ID2^ID4 and P1 = NOT(ID1^ID3^ID4^ID5). When the parity does not match, `parity_err` pulses and the frame is dropped.
- R4: The entry for ID n is `cfg_table[6n+5:6n]`. Bits 1:0 give the direction: 01 means consume, 10 means answer, and 00 or 11 means ignore. Bits 4:2 give the byte count minus one. Bit 5 selects the enhanced checksum. A frame whose ID is set to ignore produces no strobe, no flag and no transmit activity.
- R5: IDs 0x3E and 0x3F are never consumed and never answered, whatever their table entries say.
- R6: A consumed frame of N bytes (1 to 8) leads to one `rx_valid` pulse. The pulse carries `rx_id`, `rx_count` = N and `rx_data`, where byte k sits in bits 8k+7:8k (first byte in bits 7:0) and unused bytes read as zero.
- R7: The checksum is the inverted 8-bit sum of the covered bytes. Each addition that reaches 256 or more has 255 subtracted. The classic model covers only the data bytes. The enhanced model also covers the identifier byte. A received frame is accepted only when the running sum plus the received checksum byte gives 0xFF. Otherwise `csum_err` pulses and no strobe is given.
- R8: IDs 0x3C and 0x3D always use the classic checksum, even when bit 5 of their entry is set.
- R9: For an answered frame, the block waits one bit time after the identifier byte. It then sends N bytes of `tx_data`, lowest byte first, followed by the computed checksum. Each byte is sent as one low start bit, eight data bits with bit 0 first, and one high stop bit. `tx_o` stays high at all other times.
- R10: A low stop bit on any byte after the break pulses `frame_err` and abandons the frame.
- R11: A new break at any point in a frame abandons that frame and restarts header reception. The frame that follows is handled normally.
- R12: `rx_valid`, `parity_err`, `csum_err` and `frame_err` each last one clock, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling strobe, OVS per bit time |
| rx_i | input | 1 | Bus receive line (asynchronous) |
| tx_o | output | 1 | Bus transmit line, high when idle |
| cfg_table | input | 384 | Per-ID direction, length and checksum model, 6 bits per ID |
| tx_data | input | 64 | Response bytes, captured when the identifier is accepted |
| rx_valid | output | 1 | One-cycle strobe for a good consumed frame |
| rx_id | output | 6 | Frame ID of the reported frame |
| rx_count | output | 4 | Number of data bytes of the reported frame |
| rx_data | output | 64 | Received data bytes |
| parity_err | output | 1 | One-cycle identifier parity error |
| csum_err | output | 1 | One-cycle checksum error |
| frame_err | output | 1 | One-cycle stop-bit error |

## Verification
The assertions rely on `os_tick` being a strobe of one clock, spaced widely enough that a bit time spans several clocks. They also rely on `cfg_table` and `tx_data` staying stable while a frame is in progress. Under those conditions the transmit line can only go low in the transmit state. The stimulus drives the tick every second clock and the bus at 16 clocks per bit. It changes the table only between frames and moves the line only on falling clock edges, so every byte keeps the timing the receiver expects.

// File: rtl/lin_pkg.sv
package lin_pkg;

    localparam int MAX_BYTES = 8;
    localparam int LEN_W     = $clog2(MAX_BYTES);
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);
    localparam int ID_W      = 6;
    localparam int NUM_IDS   = 1 << ID_W;
    localparam int CFG_W     = 1 + LEN_W + 2;

    localparam logic [7:0]      SYNC_BYTE   = 8'h55;
    localparam logic [ID_W-1:0] ID_RSVD_LO  = 6'h3E;

    typedef enum logic [1:0] {
        DIR_NONE = 2'b00,
        DIR_RX   = 2'b01,
        DIR_TX   = 2'b10,
        DIR_OFF  = 2'b11
    } dir_e;

    typedef struct packed {
        logic             enh;
        logic [LEN_W-1:0] len_m1;
        dir_e             dir;
    } cfg_t;

    typedef enum logic [2:0] {
        S_IDLE, S_BRK, S_SYNC, S_PID, S_RXD, S_GAP, S_TXD
    } st_e;

    function automatic logic [7:0] pid_of(input logic [ID_W-1:0] id);
        logic p0, p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return {p1, p0, id};
    endfunction

    // 8-bit addition with end-around carry
    function automatic logic [7:0] cks_add(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s[8]) s = s - 9'd255;
        return s[7:0];
    endfunction

endpackage

// File: rtl/lin_uart_rx.sv
module lin_uart_rx #(
    parameter int OVS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd,
    output logic       byte_v,
    output logic [7:0] byte_d,
    output logic       byte_ferr
);
    localparam int CW   = $clog2(OVS);
    localparam int HALF = OVS / 2;

    typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rx_st_e;

    rx_st_e        st;
    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    sh;
    logic          prev_hi;

    always_ff @(posedge clk) begin
        byte_v <= 1'b0;
        if (rst) begin
            st        <= R_IDLE;
            cnt       <= '0;
            bitn      <= '0;
            sh        <= '0;
            prev_hi   <= 1'b0;
            byte_d    <= '0;
            byte_ferr <= 1'b0;
        end else if (tick) begin
            case (st)
                R_IDLE: begin
                    prev_hi <= rxd;
                    if (prev_hi && !rxd) begin
                        st  <= R_START;
                        cnt <= '0;
                    end
                end
                R_START: begin
                    if (cnt == CW'(HALF - 1)) begin
                        cnt  <= '0;
                        bitn <= '0;
                        st   <= rxd ? R_IDLE : R_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                R_DATA: begin
                    if (cnt == CW'(OVS - 1)) begin
                        cnt  <= '0;
                        sh   <= {rxd, sh[7:1]};
                        bitn <= bitn + 1'b1;
                        if (bitn == 3'd7) st <= R_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == CW'(OVS - 1)) begin
                        cnt       <= '0;
                        byte_v    <= 1'b1;
                        byte_d    <= sh;
                        byte_ferr <= ~rxd;
                        prev_hi   <= rxd;
                        st        <= R_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/lin_uart_tx.sv
module lin_uart_tx #(
    parameter int OVS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       start,
    input  logic       abort,
    input  logic [7:0] din,
    output logic       txd,
    output logic       busy,
    output logic       done
);
    localparam int CW = $clog2(OVS);

    logic [9:0]    sh;
    logic [3:0]    nb;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst) begin
            sh   <= '1;
            nb   <= '0;
            cnt  <= '0;
            busy <= 1'b0;
        end else if (abort) begin
            busy <= 1'b0;
            sh   <= '1;
        end else if (start && !busy) begin
            sh   <= {1'b1, din, 1'b0};
            nb   <= '0;
            cnt  <= '0;
            busy <= 1'b1;
        end else if (busy && tick) begin
            if (cnt == CW'(OVS - 1)) begin
                cnt <= '0;
                sh  <= {1'b1, sh[9:1]};
                if (nb == 4'd9) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    nb <= nb + 1'b1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign txd = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/lin_break_det.sv
module lin_break_det #(
    parameter int OVS      = 8,
    parameter int BRK_BITS = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rxd,
    output logic brk_low,
    output logic brk_done
);
    localparam int LIM = OVS * BRK_BITS;
    localparam int LW  = $clog2(LIM + 1);
    localparam int HW  = $clog2(OVS + 1);

    logic [LW-1:0] lowc;
    logic [HW-1:0] hic;
    logic          long_q;

    always_ff @(posedge clk) begin
        brk_low  <= 1'b0;
        brk_done <= 1'b0;
        if (rst) begin
            lowc   <= '0;
            hic    <= '0;
            long_q <= 1'b0;
        end else if (tick) begin
            if (!rxd) begin
                hic <= '0;
                if (lowc != LW'(LIM)) begin
                    lowc <= lowc + 1'b1;
                    if (lowc == LW'(LIM - 1)) begin
                        brk_low <= 1'b1;
                        long_q  <= 1'b1;
                    end
                end
            end else begin
                lowc <= '0;
                if (long_q) begin
                    if (hic == HW'(OVS - 1)) begin
                        brk_done <= 1'b1;
                        long_q   <= 1'b0;
                        hic      <= '0;
                    end else begin
                        hic <= hic + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/lin_slave_responder.sv
module lin_slave_responder
    import lin_pkg::*;
#(
    parameter int OVS      = 8,
    parameter int BRK_BITS = 13
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        os_tick,
    input  logic                        rx_i,
    output logic                        tx_o,
    input  logic [NUM_IDS*CFG_W-1:0]    cfg_table,
    input  logic [MAX_BYTES*8-1:0]      tx_data,
    output logic                        rx_valid,
    output logic [ID_W-1:0]             rx_id,
    output logic [CNT_W-1:0]            rx_count,
    output logic [MAX_BYTES*8-1:0]      rx_data,
    output logic                        parity_err,
    output logic                        csum_err,
    output logic                        frame_err
);
    localparam int GW = $clog2(OVS);

    logic rx_s1, rx_s2;
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_s1 <= 1'b1;
            rx_s2 <= 1'b1;
        end else begin
            rx_s1 <= rx_i;
            rx_s2 <= rx_s1;
        end
    end

    logic       byte_v, byte_ferr;
    logic [7:0] byte_d;
    logic       brk_low, brk_done;
    logic       tx_start, tx_busy, tx_done;
    logic [7:0] tx_byte;

    lin_uart_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst(rst), .tick(os_tick), .rxd(rx_s2),
        .byte_v(byte_v), .byte_d(byte_d), .byte_ferr(byte_ferr)
    );

    lin_break_det #(.OVS(OVS), .BRK_BITS(BRK_BITS)) u_brk (
        .clk(clk), .rst(rst), .tick(os_tick), .rxd(rx_s2),
        .brk_low(brk_low), .brk_done(brk_done)
    );

    lin_uart_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst(rst), .tick(os_tick), .start(tx_start),
        .abort(brk_low), .din(tx_byte), .txd(tx_o), .busy(tx_busy),
        .done(tx_done)
    );

    st_e                    st;
    cfg_t                   lk;
    logic                   diag;
    logic [ID_W-1:0]        id_q;
    logic [CNT_W-1:0]       len_q, idx_q;
    logic [7:0]             sum_q;
    logic [GW-1:0]          gap_q;
    logic [MAX_BYTES*8-1:0] rx_buf, tx_buf;
    logic [7:0]             cur_tx;

    always_comb begin
        lk     = cfg_t'(cfg_table[byte_d[ID_W-1:0]*CFG_W +: CFG_W]);
        diag   = (byte_d[ID_W-1:1] == 5'b11110);
        cur_tx = tx_buf[idx_q[LEN_W-1:0]*8 +: 8];
    end

    always_ff @(posedge clk) begin
        rx_valid   <= 1'b0;
        parity_err <= 1'b0;
        csum_err   <= 1'b0;
        frame_err  <= 1'b0;
        tx_start   <= 1'b0;
        if (rst) begin
            st      <= S_IDLE;
            id_q    <= '0;
            len_q   <= '0;
            idx_q   <= '0;
            sum_q   <= '0;
            gap_q   <= '0;
            rx_buf  <= '0;
            tx_buf  <= '0;
            tx_byte <= 8'hFF;
        end else if (brk_low) begin
            st <= S_BRK;
        end else begin
            case (st)
                S_BRK: if (brk_done) st <= S_SYNC;
                S_SYNC: if (byte_v) begin
                    if (byte_ferr) begin
                        frame_err <= 1'b1;
                        st        <= S_IDLE;
                    end else begin
                        st <= (byte_d == SYNC_BYTE) ? S_PID : S_IDLE;
                    end
                end
                S_PID: if (byte_v) begin
                    if (byte_ferr) begin
                        frame_err <= 1'b1;
                        st        <= S_IDLE;
                    end else if (pid_of(byte_d[ID_W-1:0]) != byte_d) begin
                        parity_err <= 1'b1;
                        st         <= S_IDLE;
                    end else if (byte_d[ID_W-1:0] >= ID_RSVD_LO ||
                                 lk.dir == DIR_NONE || lk.dir == DIR_OFF) begin
                        st <= S_IDLE;
                    end else begin
                        id_q   <= byte_d[ID_W-1:0];
                        len_q  <= CNT_W'(lk.len_m1) + CNT_W'(1);
                        idx_q  <= '0;
                        sum_q  <= (lk.enh && !diag) ? byte_d : 8'h00;
                        gap_q  <= '0;
                        rx_buf <= '0;
                        tx_buf <= tx_data;
                        st     <= (lk.dir == DIR_TX) ? S_GAP : S_RXD;
                    end
                end
                S_RXD: if (byte_v) begin
                    if (byte_ferr) begin
                        frame_err <= 1'b1;
                        st        <= S_IDLE;
                    end else if (idx_q < len_q) begin
                        rx_buf[idx_q[LEN_W-1:0]*8 +: 8] <= byte_d;
                        sum_q <= cks_add(sum_q, byte_d);
                        idx_q <= idx_q + 1'b1;
                    end else begin
                        if (cks_add(sum_q, byte_d) == 8'hFF) rx_valid <= 1'b1;
                        else                                 csum_err <= 1'b1;
                        st <= S_IDLE;
                    end
                end
                S_GAP: if (os_tick) begin
                    if (gap_q == GW'(OVS - 1)) begin
                        tx_start <= 1'b1;
                        tx_byte  <= cur_tx;
                        sum_q    <= cks_add(sum_q, cur_tx);
                        idx_q    <= idx_q + 1'b1;
                        st       <= S_TXD;
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                S_TXD: if (tx_done) begin
                    if (idx_q < len_q) begin
                        tx_start <= 1'b1;
                        tx_byte  <= cur_tx;
                        sum_q    <= cks_add(sum_q, cur_tx);
                        idx_q    <= idx_q + 1'b1;
                    end else if (idx_q == len_q) begin
                        tx_start <= 1'b1;
                        tx_byte  <= ~sum_q;
                        idx_q    <= idx_q + 1'b1;
                    end else begin
                        st <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign rx_id    = id_q;
    assign rx_count = len_q;
    assign rx_data  = rx_buf;

endmodule

// File: rtl/lin_slave_responder_chk.sv
module lin_slave_responder_chk
    import lin_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic             parity_err,
    input logic             csum_err,
    input logic             frame_err,
    input logic [ID_W-1:0]  rx_id,
    input logic [CNT_W-1:0] rx_count,
    input logic             tx_o,
    input st_e              st
);
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_valid, parity_err, csum_err, frame_err}));          // R12
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);                                           // R12
    AST_PERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        parity_err |=> !parity_err);                                       // R3
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (rx_count >= CNT_W'(1) && rx_count <= CNT_W'(MAX_BYTES))); // R6
    AST_NO_RSVD: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (rx_id < ID_RSVD_LO));                                // R5
    AST_TX_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st != S_TXD) |-> tx_o);                                           // R9
endmodule

bind lin_slave_responder lin_slave_responder_chk u_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .parity_err(parity_err),
    .csum_err(csum_err), .frame_err(frame_err), .rx_id(rx_id),
    .rx_count(rx_count), .tx_o(tx_o), .st(st)
);

// File: tb/lin_slave_responder_tb.sv
`timescale 1ns/1ps
module lin_slave_responder_tb;
    localparam int BIT_CLK = 16;   // OVS 8, tick every 2 clocks

    logic         clk, rst, os_tick, m_tx;
    logic         tx_o, rx_i;
    logic [383:0] cfg_table;
    logic [63:0]  tx_data;
    logic         rx_valid, parity_err, csum_err, frame_err;
    logic [5:0]   rx_id;
    logic [3:0]   rx_count;
    logic [63:0]  rx_data;

    int checks = 0, errors = 0;
    int n_valid, n_perr, n_cerr, n_ferr, n_txlow;
    logic [5:0]  cap_id;
    logic [3:0]  cap_cnt;
    logic [63:0] cap_data;
    bit finished = 0;

    assign rx_i = m_tx & tx_o;

    lin_slave_responder u_dut (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rx_i(rx_i), .tx_o(tx_o),
        .cfg_table(cfg_table), .tx_data(tx_data), .rx_valid(rx_valid),
        .rx_id(rx_id), .rx_count(rx_count), .rx_data(rx_data),
        .parity_err(parity_err), .csum_err(csum_err), .frame_err(frame_err)
    );

    initial begin clk = 1'b0; forever #2.5 clk = ~clk; end
    initial begin os_tick = 1'b0; forever begin @(negedge clk); os_tick = ~os_tick; end end

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                n_valid++; cap_id = rx_id; cap_cnt = rx_count; cap_data = rx_data;
            end
            if (parity_err) n_perr++;
            if (csum_err)   n_cerr++;
            if (frame_err)  n_ferr++;
            if (!tx_o)      n_txlow++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pid(input logic [5:0] id);
        logic a, b;
        a = id[0] ^ id[1] ^ id[2] ^ id[4];
        b = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return {b, a, id};
    endfunction

    function automatic logic [7:0] cks(input logic [7:0] seed, input logic [63:0] d, input int n);
        int s; logic [7:0] r;
        s = seed;
        for (int k = 0; k < n; k++) begin
            s = s + d[8*k +: 8];
            if (s > 255) s = s - 255;
        end
        r = s[7:0];
        return ~r;
    endfunction

    task automatic set_cfg(input logic [5:0] id, input logic [1:0] dir, input int len, input logic enh);
        logic [2:0] lm;
        lm = 3'(len - 1);
        cfg_table[id*6 +: 6] = {enh, lm, dir};
    endtask

    task automatic clr_cnt();
        n_valid = 0; n_perr = 0; n_cerr = 0; n_ferr = 0; n_txlow = 0;
    endtask

    task automatic send_bits(input logic v, input int n);
        m_tx = v;
        repeat (n * BIT_CLK) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stop_v = 1'b1);
        send_bits(1'b0, 1);
        for (int i = 0; i < 8; i++) send_bits(b[i], 1);
        send_bits(stop_v, 1);
        m_tx = 1'b1;
    endtask

    task automatic send_header(input logic [7:0] p, input logic [7:0] sy = 8'h55, input int brk = 14);
        send_bits(1'b0, brk);
        send_bits(1'b1, 2);
        send_byte(sy);
        send_byte(p);
    endtask

    task automatic send_data(input logic [63:0] d, input int n, input logic [7:0] cs);
        for (int k = 0; k < n; k++) send_byte(d[8*k +: 8]);
        send_byte(cs);
        send_bits(1'b1, 2);
    endtask

    task automatic grab_byte(output logic [7:0] b, output bit ok);
        int t;
        ok = 1; b = '0; t = 0;
        while (tx_o !== 1'b0 && t < 400) begin @(negedge clk); t++; end
        if (t >= 400) begin ok = 0; return; end
        repeat (BIT_CLK / 2) @(negedge clk);
        if (tx_o !== 1'b0) ok = 0;
        for (int i = 0; i < 8; i++) begin repeat (BIT_CLK) @(negedge clk); b[i] = tx_o; end
        repeat (BIT_CLK) @(negedge clk);
        if (tx_o !== 1'b1) ok = 0;
    endtask

    task automatic t_reset();
        chk(tx_o === 1'b1, "R9 idle tx high after reset", 64'(tx_o), 1);
        chk(rx_valid === 1'b0 && frame_err === 1'b0, "R12 no pulse after reset", 64'(rx_valid), 0);
    endtask

    task automatic t_rx_classic();
        logic [63:0] d = 64'h3412;
        clr_cnt();
        send_header(pid(6'h10));
        send_data(d, 2, cks(8'h00, d, 2));
        chk(n_valid == 1, "R6 classic frame strobe", n_valid, 1);
        chk(cap_id == 6'h10, "R6 id", cap_id, 6'h10);
        chk(cap_cnt == 4'd2, "R6 count", cap_cnt, 2);
        chk(cap_data == d, "R6 data placement", cap_data, d);
    endtask

    task automatic t_rx_enh();
        logic [63:0] d = 64'h80FF_FFFE_0102_F0F1;
        clr_cnt();
        send_header(pid(6'h21));
        send_data(d, 8, cks(pid(6'h21), d, 8));
        chk(n_valid == 1 && n_cerr == 0, "R7 enhanced wraparound accepted", n_valid, 1);
        chk(cap_data == d && cap_cnt == 4'd8, "R7 enhanced data", cap_data, d);
        clr_cnt();
        send_header(pid(6'h21));
        send_data(d, 8, cks(8'h00, d, 8));
        chk(n_cerr == 1 && n_valid == 0, "R7 classic sum on enhanced id rejected", n_cerr, 1);
        clr_cnt();
        send_header(pid(6'h10));
        send_data(64'h3412, 2, cks(8'h00, 64'h3412, 2) ^ 8'h01);
        chk(n_cerr == 1 && n_valid == 0, "R7 corrupted checksum", n_cerr, 1);
    endtask

    task automatic t_tx(input logic [5:0] id, input int n, input logic [7:0] seed, input string req);
        logic [7:0] b; bit ok;
        clr_cnt();
        send_header(pid(id));
        for (int k = 0; k < n; k++) begin
            grab_byte(b, ok);
            chk(ok && b == tx_data[8*k +: 8], req, b, tx_data[8*k +: 8]);
        end
        grab_byte(b, ok);
        chk(ok && b == cks(seed, tx_data, n), {req, " checksum"}, b, cks(seed, tx_data, n));
        send_bits(1'b1, 3);
        chk(tx_o === 1'b1 && n_valid == 0, "R9 line released", 64'(tx_o), 1);
    endtask

    task automatic t_diag_rx();
        logic [63:0] d = 64'h0706_0504_0302_01B4;
        clr_cnt();
        send_header(pid(6'h3C));
        send_data(d, 8, cks(8'h00, d, 8));
        chk(n_valid == 1 && cap_id == 6'h3C, "R8 diag request classic", n_valid, 1);
    endtask

    task automatic t_parity();
        clr_cnt();
        send_header(pid(6'h10) ^ 8'h80);
        send_data(64'h3412, 2, cks(8'h00, 64'h3412, 2));
        chk(n_perr == 1 && n_valid == 0, "R3 bad P1 rejected", n_perr, 1);
        clr_cnt();
        send_header(pid(6'h05) ^ 8'h40);
        send_bits(1'b1, 20);
        chk(n_perr == 1 && n_txlow == 0, "R3 bad P0 no response", n_perr, 1);
    endtask

    task automatic t_sync();
        clr_cnt();
        send_header(pid(6'h10), 8'h54);
        send_data(64'h3412, 2, cks(8'h00, 64'h3412, 2));
        chk(n_valid == 0 && n_perr + n_cerr + n_ferr == 0, "R2 bad sync silent", n_valid, 0);
    endtask

    task automatic t_short();
        clr_cnt();
        send_header(pid(6'h10), 8'h55, 10);
        send_data(64'h3412, 2, cks(8'h00, 64'h3412, 2));
        chk(n_valid == 0 && n_ferr == 0, "R1 short low not a break", n_valid, 0);
    endtask

    task automatic t_rsvd();
        clr_cnt();
        send_header(pid(6'h3E));
        send_data(64'h11, 1, cks(8'h00, 64'h11, 1));
        chk(n_valid == 0, "R5 reserved 3E ignored", n_valid, 0);
        clr_cnt();
        send_header(pid(6'h3F));
        send_bits(1'b1, 30);
        chk(n_txlow == 0, "R5 reserved 3F not answered", n_txlow, 0);
    endtask

    task automatic t_none();
        clr_cnt();
        send_header(pid(6'h11));
        send_data(64'h3412, 2, cks(8'h00, 64'h3412, 2));
        chk(n_valid == 0 && n_txlow == 0 && n_cerr == 0, "R4 ignored id", n_valid, 0);
    endtask

    task automatic t_ferr();
        clr_cnt();
        send_header(pid(6'h10));
        send_byte(8'h12, 1'b0);
        send_bits(1'b1, 3);
        send_data(64'h0, 0, 8'h00);
        chk(n_ferr == 1 && n_valid == 0, "R10 low stop bit", n_ferr, 1);
    endtask

    task automatic t_midbrk();
        clr_cnt();
        send_header(pid(6'h21));
        send_byte(8'hAA); send_byte(8'hBB); send_byte(8'hCC);
        send_header(pid(6'h10));
        send_data(64'h3412, 2, cks(8'h00, 64'h3412, 2));
        chk(n_valid == 1 && cap_id == 6'h10, "R11 restart after break", cap_id, 6'h10);
    endtask

    initial begin
        rst = 1'b1; m_tx = 1'b1; cfg_table = '0;
        tx_data = 64'hF1E2_D3C4_B5A6_9788;
        clr_cnt();
        set_cfg(6'h10, 2'b01, 2, 1'b0);
        set_cfg(6'h21, 2'b01, 8, 1'b1);
        set_cfg(6'h05, 2'b10, 4, 1'b1);
        set_cfg(6'h3D, 2'b10, 8, 1'b1);
        set_cfg(6'h3C, 2'b01, 8, 1'b1);
        set_cfg(6'h3E, 2'b01, 1, 1'b0);
        set_cfg(6'h3F, 2'b10, 2, 1'b0);
        set_cfg(6'h11, 2'b11, 2, 1'b0);
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (40) @(negedge clk);
        t_reset();
        t_rx_classic();
        t_rx_enh();
        t_tx(6'h05, 4, pid(6'h05), "R9 enhanced response");
        t_tx(6'h3D, 8, 8'h00, "R8 diag response classic");
        t_diag_rx();
        t_parity();
        t_sync();
        t_short();
        t_rsvd();
        t_none();
        t_ferr();
        t_midbrk();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule